// File: doc/BRIEF.md
# Row-Buffer-Miss Migration Decision Unit

This block sits beside the controller of the slow, dense half of a hybrid main memory, where a small fast memory serves as a cache. It observes every request sent to the slow memory, each given as a bank index and a row address. For each bank it remembers the row currently held open, so it can label each access a row buffer hit or a row buffer miss. Rows that keep missing are the ones that lose the most by staying in slow memory, so those are the ones worth moving.

A small fully associative table follows the recently used rows and counts only their row buffer misses. When a row's count reaches the current threshold, the block offers a migrate request on a valid/ready output. The address it carries is the row's key aligned to the 1 KB migration unit. Every table entry is wiped on a fixed cycle period, so a row must build up its misses within a single period. The threshold itself is retuned at the end of each fixed interval. The block compares an estimate of the latency saved by that interval's migrations against their fixed cost.

Top module: `rbm_migrate_unit`

## Requirements
- R1: After reset, `mig_valid` is low, every bank has no open row, the tracking table is empty and the threshold equals `THR_INIT`.
- R2: Each bank keeps its own open row. An access to that row is a hit. Any other access to the bank is a miss and makes the new row the open one. Accesses to one bank never change another bank's open row.
- R3: Only row buffer misses add one to a tracked row's count, which saturates at 2^CNT_W-1. Row buffer hits leave the count unchanged.
- R4: A miss to an untracked row allocates an entry with count 1. A free entry is used first; otherwise the least recently used entry is replaced. Both misses and hits to a tracked row make it the most recently used.
- R5: When a miss brings a row's count to a value at or above the threshold, the block raises `mig_valid` on the next cycle with `mig_addr` = {bank, row, GRAN_BITS zero bits}. It also drops that row's entry, so a later miss to the row starts again at count 1. A row whose first miss already meets the threshold is requested without being allocated.
- R6: `mig_valid` and `mig_addr` hold until `mig_ready` is high at a clock edge. While a request is pending, a row that reaches the threshold is not requested and stays in the table with its raised count.
- R7: On every CLEAR_CYC-th cycle after reset, all table entries are dropped. Open rows are kept.
- R8: On every INTERVAL_CYC-th cycle after reset, the interval's benefit is compared with its cost. Benefit is the sum, over migrations, of (count at trigger) x (SLOW_MISS_LAT - FAST_MISS_LAT). Cost is the migration count x MIG_COST. If benefit < cost the threshold rises by one; otherwise it falls by one. Both sums then restart. The threshold changes at no other time.
- R9: The threshold never goes below 1 or above 2^CNT_W-1.
- R10: A new migrate request appears only in the cycle after a request was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A slow-memory access is presented this cycle |
| req_bank | input | $clog2(NUM_BANKS) | Bank index of the access |
| req_row | input | ROW_W | Row address within the bank |
| mig_valid | output | 1 | Migrate request pending |
| mig_ready | input | 1 | Consumer accepts the pending migrate request |
| mig_addr | output | $clog2(NUM_BANKS)+ROW_W+GRAN_BITS | 1 KB-aligned address of the row to migrate |

## Verification
The bench builds the unit with 8 banks, 12-bit rows, a 16-entry table and a starting threshold of 4. It uses a 1000-cycle tuning interval, a 300-cycle clearing period, miss latencies of 40 and 10, and a migration cost of 200. With these values a migration triggered at a count below 7 is judged unprofitable. The threshold therefore climbs after busy intervals and falls by one per idle interval, which brings the floor clamp within reach in about eight thousand cycles. The short clearing period lets the bench show counts being wiped between two bursts of misses. Seventeen distinct rows are enough to force an LRU eviction.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

    typedef enum logic {
        ACC_HIT  = 1'b0,
        ACC_MISS = 1'b1
    } acc_kind_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rbm_open_row.sv
module rbm_open_row
    import rbm_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    localparam int BANK_W   = idx_width(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    output acc_kind_e         kind_o
);

    typedef struct packed {
        logic [NUM_BANKS-1:0]            open;
        logic [NUM_BANKS-1:0][ROW_W-1:0] row;
    } orow_t;

    orow_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        kind_o = (st_q.open[req_bank] && (st_q.row[req_bank] == req_row)) ? ACC_HIT : ACC_MISS;
        if (req_valid) begin
            st_d.open[req_bank] = 1'b1;
            st_d.row[req_bank]  = req_row;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rbm_track_table.sv
module rbm_track_table
    import rbm_pkg::*;
#(
    parameter int KEY_W   = 17,
    parameter int TRACK_N = 16,
    parameter int CNT_W   = 4,
    localparam int IDX_W  = idx_width(TRACK_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  acc_kind_e        acc_kind,
    input  logic [KEY_W-1:0] acc_key,
    input  logic [CNT_W-1:0] thr_i,
    input  logic             slot_free_i,
    input  logic             clear_i,
    output logic             fire_o,
    output logic [CNT_W-1:0] fire_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [IDX_W-1:0] LRU_RANK = IDX_W'(TRACK_N - 1);

    typedef struct packed {
        logic [TRACK_N-1:0]            valid;
        logic [TRACK_N-1:0][KEY_W-1:0] key;
        logic [TRACK_N-1:0][CNT_W-1:0] cnt;
        logic [TRACK_N-1:0][IDX_W-1:0] rank;   // 0 = most recently used
    } tab_t;

    tab_t st_d, st_q;

    logic [TRACK_N-1:0] match;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   lru_idx;
    logic [IDX_W-1:0]   victim;
    logic [IDX_W-1:0]   tidx;
    logic [IDX_W-1:0]   old_rank;
    logic [CNT_W-1:0]   cur_cnt;
    logic [CNT_W-1:0]   cnt_new;
    logic               is_miss;
    logic               touch;

    for (genvar g = 0; g < TRACK_N; g++) begin : g_cmp
        assign match[g] = st_q.valid[g] && (st_q.key[g] == acc_key);
    end

    always_comb begin
        hit_any  = |match;
        hit_idx  = '0;
        free_idx = '0;
        lru_idx  = '0;
        for (int i = TRACK_N - 1; i >= 0; i--) begin
            if (match[i])          hit_idx  = IDX_W'(i);
            if (!st_q.valid[i])    free_idx = IDX_W'(i);
            if (st_q.rank[i] == LRU_RANK) lru_idx = IDX_W'(i);
        end
        victim  = (&st_q.valid) ? lru_idx : free_idx;
        cur_cnt = st_q.cnt[hit_idx];
        cnt_new = hit_any ? ((cur_cnt == CNT_MAX) ? CNT_MAX : cur_cnt + 1'b1) : CNT_W'(1);
        is_miss = acc_valid && (acc_kind == ACC_MISS);
        fire_o  = is_miss && (cnt_new >= thr_i) && slot_free_i;
        fire_cnt_o = cnt_new;

        // recency refresh: any access to a tracked row, or a new allocation
        touch = acc_valid && (hit_any || (is_miss && !fire_o));
        tidx  = hit_any ? hit_idx : victim;
        old_rank = st_q.rank[tidx];

        st_d = st_q;
        if (touch) begin
            for (int i = 0; i < TRACK_N; i++) begin
                if (st_q.rank[i] < old_rank) st_d.rank[i] = st_q.rank[i] + 1'b1;
            end
            st_d.rank[tidx] = '0;
        end
        if (is_miss) begin
            if (hit_any) begin
                st_d.cnt[hit_idx]   = cnt_new;
                st_d.valid[hit_idx] = !fire_o;
            end else if (!fire_o) begin
                st_d.key[victim]   = acc_key;
                st_d.cnt[victim]   = cnt_new;
                st_d.valid[victim] = 1'b1;
            end
        end
        if (clear_i) begin
            st_d.valid = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            st_q.key   <= '0;
            st_q.cnt   <= '0;
            for (int i = 0; i < TRACK_N; i++) begin
                st_q.rank[i] <= IDX_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rbm_thresh_ctl.sv
module rbm_thresh_ctl #(
    parameter int CNT_W         = 4,
    parameter int THR_INIT      = 4,
    parameter int INTERVAL_CYC  = 4096,
    parameter int CLEAR_CYC     = 16384,
    parameter int SLOW_MISS_LAT = 48,
    parameter int FAST_MISS_LAT = 16,
    parameter int MIG_COST      = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mig_fire_i,
    input  logic [CNT_W-1:0] mig_cnt_i,
    output logic [CNT_W-1:0] thr_o,
    output logic             clear_o,
    output logic             ivl_end_o
);

    localparam int SAVE     = SLOW_MISS_LAT - FAST_MISS_LAT;
    localparam int IT_W     = $clog2(INTERVAL_CYC + 1);
    localparam int CT_W     = $clog2(CLEAR_CYC + 1);
    localparam int BEN_MAX  = INTERVAL_CYC * ((1 << CNT_W) - 1) * SAVE;
    localparam int COST_MAX = INTERVAL_CYC * MIG_COST;
    localparam int STAT_W   = $clog2(((BEN_MAX > COST_MAX) ? BEN_MAX : COST_MAX) + 1);
    localparam logic [CNT_W-1:0] THR_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] THR_MIN = CNT_W'(1);

    typedef struct packed {
        logic [IT_W-1:0]   ivl_t;
        logic [CT_W-1:0]   clr_t;
        logic [CNT_W-1:0]  thr;
        logic [STAT_W-1:0] ben;
        logic [STAT_W-1:0] cost;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [STAT_W-1:0] ben_add;
    logic [STAT_W-1:0] cost_add;

    always_comb begin
        ivl_end_o = (st_q.ivl_t == IT_W'(INTERVAL_CYC - 1));
        clear_o   = (st_q.clr_t == CT_W'(CLEAR_CYC - 1));
        ben_add   = mig_fire_i ? STAT_W'(mig_cnt_i) * STAT_W'(SAVE) : '0;
        cost_add  = mig_fire_i ? STAT_W'(MIG_COST) : '0;
        thr_o     = st_q.thr;

        st_d       = st_q;
        st_d.ivl_t = ivl_end_o ? '0 : st_q.ivl_t + 1'b1;
        st_d.clr_t = clear_o   ? '0 : st_q.clr_t + 1'b1;
        if (ivl_end_o) begin
            if (st_q.ben < st_q.cost) begin
                st_d.thr = (st_q.thr == THR_MAX) ? THR_MAX : st_q.thr + 1'b1;
            end else begin
                st_d.thr = (st_q.thr <= THR_MIN) ? THR_MIN : st_q.thr - 1'b1;
            end
            st_d.ben  = ben_add;
            st_d.cost = cost_add;
        end else begin
            st_d.ben  = st_q.ben + ben_add;
            st_d.cost = st_q.cost + cost_add;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.thr <= CNT_W'(THR_INIT);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rbm_migrate_unit.sv
module rbm_migrate_unit
    import rbm_pkg::*;
#(
    parameter int NUM_BANKS     = 8,
    parameter int ROW_W         = 14,
    parameter int TRACK_N       = 16,
    parameter int CNT_W         = 4,
    parameter int THR_INIT      = 4,
    parameter int INTERVAL_CYC  = 4096,
    parameter int CLEAR_CYC     = 16384,
    parameter int SLOW_MISS_LAT = 48,
    parameter int FAST_MISS_LAT = 16,
    parameter int MIG_COST      = 256,
    parameter int GRAN_BITS     = 10,
    localparam int BANK_W       = idx_width(NUM_BANKS),
    localparam int KEY_W        = BANK_W + ROW_W,
    localparam int ADDR_W       = KEY_W + GRAN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    output logic              mig_valid,
    input  logic              mig_ready,
    output logic [ADDR_W-1:0] mig_addr
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } mig_t;

    mig_t             mig_d, mig_q;
    acc_kind_e        kind;
    logic [KEY_W-1:0] key;
    logic [CNT_W-1:0] thr_w;
    logic [CNT_W-1:0] fire_cnt;
    logic             fire;
    logic             clear_w;
    logic             ivl_end_w;
    logic             slot_free;

    assign key       = {req_bank, req_row};
    assign slot_free = !mig_q.valid || mig_ready;

    rbm_open_row #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) u_open_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .kind_o    (kind)
    );

    rbm_track_table #(
        .KEY_W   (KEY_W),
        .TRACK_N (TRACK_N),
        .CNT_W   (CNT_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (req_valid),
        .acc_kind    (kind),
        .acc_key     (key),
        .thr_i       (thr_w),
        .slot_free_i (slot_free),
        .clear_i     (clear_w),
        .fire_o      (fire),
        .fire_cnt_o  (fire_cnt)
    );

    rbm_thresh_ctl #(
        .CNT_W         (CNT_W),
        .THR_INIT      (THR_INIT),
        .INTERVAL_CYC  (INTERVAL_CYC),
        .CLEAR_CYC     (CLEAR_CYC),
        .SLOW_MISS_LAT (SLOW_MISS_LAT),
        .FAST_MISS_LAT (FAST_MISS_LAT),
        .MIG_COST      (MIG_COST)
    ) u_thresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .mig_fire_i (fire),
        .mig_cnt_i  (fire_cnt),
        .thr_o      (thr_w),
        .clear_o    (clear_w),
        .ivl_end_o  (ivl_end_w)
    );

    always_comb begin
        mig_d = mig_q;
        if (fire) begin
            mig_d.valid = 1'b1;
            mig_d.addr  = {key, {GRAN_BITS{1'b0}}};
        end else if (mig_ready) begin
            mig_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mig_q <= '0;
        end else begin
            mig_q <= mig_d;
        end
    end

    assign mig_valid = mig_q.valid;
    assign mig_addr  = mig_q.addr;

endmodule

// File: rtl/rbm_migrate_unit_chk.sv
module rbm_migrate_unit_chk #(
    parameter int ADDR_W = 27,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              mig_valid,
    input logic              mig_ready,
    input logic [ADDR_W-1:0] mig_addr,
    input logic [CNT_W-1:0]  thr,
    input logic              interval_end
);

    // R6: a pending request is held with a stable address until taken
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mig_valid && !mig_ready) |=> (mig_valid && $stable(mig_addr)));

    // R8: threshold moves only at an interval boundary
    assert_thr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !interval_end |=> $stable(thr));

    // R8: each retune is a single step
    assert_thr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (thr != $past(thr)) |-> ((thr == $past(thr) + 1'b1) || (thr == $past(thr) - 1'b1)));

    // R9: threshold never reaches zero
    assert_thr_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        thr != '0);

    // R10: a fresh migrate request follows a presented access
    assert_rise_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mig_valid) |-> $past(req_valid));

endmodule

bind rbm_migrate_unit rbm_migrate_unit_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mig_valid    (mig_valid),
    .mig_ready    (mig_ready),
    .mig_addr     (mig_addr),
    .thr          (thr_w),
    .interval_end (ivl_end_w)
);

// File: tb/rbm_migrate_unit_tb.sv
module rbm_migrate_unit_tb;

    localparam int BW = 3;
    localparam int RW = 12;
    localparam int AW = BW + RW + 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic          mig_valid;
    logic          mig_ready = 1'b1;
    logic [AW-1:0] mig_addr;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    rbm_migrate_unit #(
        .NUM_BANKS     (8),
        .ROW_W         (RW),
        .TRACK_N       (16),
        .CNT_W         (4),
        .THR_INIT      (4),
        .INTERVAL_CYC  (1000),
        .CLEAR_CYC     (300),
        .SLOW_MISS_LAT (40),
        .FAST_MISS_LAT (10),
        .MIG_COST      (200),
        .GRAN_BITS     (10)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .mig_valid (mig_valid),
        .mig_ready (mig_ready),
        .mig_addr  (mig_addr)
    );

    // {bank, row, expected trigger}; threshold is 4 here
    localparam logic [15:0] VEC [29] = '{
        {3'd0, 12'd5, 1'b0}, {3'd0, 12'd6, 1'b0}, {3'd0, 12'd5, 1'b0}, // R5 build-up
        {3'd0, 12'd6, 1'b0}, {3'd0, 12'd5, 1'b0}, {3'd0, 12'd6, 1'b0},
        {3'd0, 12'd5, 1'b1}, {3'd0, 12'd6, 1'b1}, {3'd0, 12'd5, 1'b0}, // R5 fire, re-start
        {3'd1, 12'd9, 1'b0}, {3'd1, 12'd9, 1'b0}, {3'd1, 12'd9, 1'b0}, // R3 hits
        {3'd1, 12'd9, 1'b0}, {3'd1, 12'd9, 1'b0}, {3'd1, 12'd3, 1'b0},
        {3'd1, 12'd9, 1'b0}, {3'd1, 12'd3, 1'b0}, {3'd1, 12'd9, 1'b0},
        {3'd1, 12'd3, 1'b0}, {3'd1, 12'd9, 1'b1},                      // R3 fourth miss
        {3'd3, 12'd4, 1'b0}, {3'd4, 12'd4, 1'b0}, {3'd3, 12'd4, 1'b0}, // R2 bank isolation
        {3'd3, 12'd8, 1'b0}, {3'd3, 12'd4, 1'b0}, {3'd3, 12'd8, 1'b0},
        {3'd3, 12'd4, 1'b0}, {3'd3, 12'd8, 1'b0}, {3'd3, 12'd4, 1'b1}
    };

    function automatic logic [AW-1:0] row_addr(input logic [BW-1:0] b, input logic [RW-1:0] r);
        return {b, r, 10'd0};
    endfunction

    task automatic check(input logic exp_v, input logic [AW-1:0] exp_a, input string tag);
        nvec++;
        if (mig_valid !== exp_v || (exp_v && mig_addr !== exp_a)) begin
            nfail++;
            $display("FAIL %s: mig_valid=%0b mig_addr=%h, expected mig_valid=%0b mig_addr=%h",
                     tag, mig_valid, mig_addr, exp_v, exp_a);
        end
    endtask

    // one cycle: drive at negedge, DUT registers at posedge, check at next negedge
    task automatic op(input logic en, input logic [BW-1:0] b, input logic [RW-1:0] r,
                      input logic rdy, input logic exp_v, input logic [AW-1:0] exp_a,
                      input string tag);
        req_valid = en;
        req_bank  = b;
        req_row   = r;
        mig_ready = rdy;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(exp_v, exp_a, tag);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, '0, "R1 reset");
        rst_n = 1'b1;

        // table walk, threshold 4
        for (int i = 0; i < 29; i++) begin
            op(1'b1, VEC[i][15:13], VEC[i][12:1], 1'b1, VEC[i][0],
               row_addr(VEC[i][15:13], VEC[i][12:1]), $sformatf("R2 R3 R5 vector %0d", i));
        end

        // R4: LRU eviction after the clear at cycle 300
        wait_cyc(305);
        for (int k = 0; k < 3; k++) begin
            op(1'b1, 3'd4, 12'd1, 1'b1, 1'b0, '0, "R4 fill X");
            op(1'b1, 3'd4, 12'd2, 1'b1, 1'b0, '0, "R4 fill Y");
        end
        for (int k = 0; k < 14; k++) begin
            op(1'b1, 3'd5, RW'(100 + k), 1'b1, 1'b0, '0, "R4 fill fresh");
        end
        op(1'b1, 3'd4, 12'd2, 1'b1, 1'b0, '0, "R4 hit Y");
        op(1'b1, 3'd5, 12'd114, 1'b1, 1'b0, '0, "R4 evicting fill");
        op(1'b1, 3'd4, 12'd1, 1'b1, 1'b0, '0, "R4 evicted X restarts");
        op(1'b1, 3'd4, 12'd2, 1'b1, 1'b1, row_addr(3'd4, 12'd2), "R4 kept Y fires");

        // R8: threshold raised to 5 at cycle 1000
        wait_cyc(1010);
        for (int k = 0; k < 4; k++) begin
            op(1'b1, 3'd6, 12'd20, 1'b1, 1'b0, '0, "R8 Z below 5");
            op(1'b1, 3'd6, 12'd21, 1'b1, 1'b0, '0, "R8 W below 5");
        end
        op(1'b1, 3'd6, 12'd20, 1'b1, 1'b1, row_addr(3'd6, 12'd20), "R8 Z fires at 5");

        // R7: clear at cycle 1200 wipes counts
        wait_cyc(1180);
        for (int k = 0; k < 4; k++) begin
            op(1'b1, 3'd7, 12'd10, 1'b1, 1'b0, '0, "R7 R build");
            op(1'b1, 3'd7, 12'd11, 1'b1, 1'b0, '0, "R7 S build");
        end
        wait_cyc(1205);
        op(1'b1, 3'd7, 12'd10, 1'b1, 1'b0, '0, "R7 R after clear");
        op(1'b1, 3'd7, 12'd11, 1'b1, 1'b0, '0, "R7 S after clear");

        // R6: handshake hold and blocked trigger
        wait_cyc(1300);
        for (int k = 0; k < 4; k++) begin
            op(1'b1, 3'd1, 12'd50, 1'b0, 1'b0, '0, "R6 P build");
            op(1'b1, 3'd1, 12'd51, 1'b0, 1'b0, '0, "R6 Q build");
        end
        op(1'b1, 3'd1, 12'd50, 1'b0, 1'b1, row_addr(3'd1, 12'd50), "R6 P fires");
        op(1'b1, 3'd1, 12'd51, 1'b0, 1'b1, row_addr(3'd1, 12'd50), "R6 held while Q blocked");
        op(1'b0, 3'd0, 12'd0, 1'b1, 1'b0, '0, "R6 taken");
        op(1'b1, 3'd1, 12'd50, 1'b1, 1'b0, '0, "R6 P restarts");
        op(1'b1, 3'd1, 12'd51, 1'b1, 1'b1, row_addr(3'd1, 12'd51), "R6 Q kept count fires");

        // R10: idle stretch raises nothing
        wait_cyc(2500);
        check(1'b0, '0, "R10 idle");

        // R9: threshold 6 at 2000 decays to floor 1 by 7000, stays at 8000
        wait_cyc(8010);
        op(1'b1, 3'd2, 12'd200, 1'b1, 1'b1, row_addr(3'd2, 12'd200), "R9 floor fires on first miss");

        // R8: one cheap migration lifts threshold to 2 at 9000
        wait_cyc(9010);
        op(1'b1, 3'd2, 12'd201, 1'b1, 1'b0, '0, "R8 first miss below 2");
        op(1'b1, 3'd2, 12'd200, 1'b1, 1'b0, '0, "R8 other row below 2");
        op(1'b1, 3'd2, 12'd201, 1'b1, 1'b1, row_addr(3'd2, 12'd201), "R8 second miss fires");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule